// File: doc/BRIEF.md
# Multi-Interface Basic-Rate ISDN TDM Slot Multiplexer

This block places the channel bytes of up to ten basic-rate ISDN interfaces onto one serial 2.048 Mbit/s time-division bus, and takes them off that bus in the other direction. One bit period lasts one cycle of the data clock. A frame holds 256 bit periods, which form 32 slots of 8 bits each, and it repeats at 8 kHz. A sync pulse on the data clock marks where each frame begins. Each interface owns three consecutive slots, in the order B1, B2, D. Only the first two bit periods of a D slot carry data. The last two slots of the frame belong to no interface.

On the transmit side, the block takes one snapshot of the parallel holding inputs and the per-interface enables at the start of each frame and shifts that snapshot out. The receive side samples the serial line on the falling clock edge. When a complete frame has been received, the block updates all receive outputs at once and raises a one-cycle valid strobe. A frame that is cut short by an early sync pulse gives no receive update. After the first sync pulse, the block keeps framing on its own counter if later pulses are missing.

Top module: `tdm_bri_mux`

## Requirements
- R1: Bit periods are numbered from 0 after each frame start. Period t carries slot t/8, most significant bit first. `tx_bit` changes only just after a rising clock edge.
- R2: Interface i uses slot 3i for B1 and slot 3i+1 for B2. Its bytes are `tx_b1[8i+7:8i]` and `tx_b2[8i+7:8i]` on transmit, and `rx_b1[8i+7:8i]` and `rx_b2[8i+7:8i]` on receive.
- R3: Slot 3i+2 is the D slot of interface i. Its first two bit periods carry `tx_d[2i+1]` and then `tx_d[2i]`, and the remaining six periods are driven 1. On receive, `rx_d[2i+1]` and `rx_d[2i]` take the first two bits of the slot, and the other six bits have no effect on any output.
- R4: Slots 30 and 31 are driven 1 on transmit. Received bits in these slots have no effect on any output.
- R5: If `if_en[i]` is 0 at a frame start, all three slots of interface i are driven 1 for that whole frame.
- R6: The holding inputs and `if_en` are sampled only at a frame start. Changing them during a frame does not alter the bits sent in that frame.
- R7: `rx_bit` is sampled on the falling clock edge. At the rising edge that ends bit period 255, all receive outputs update together and `rx_valid` goes high for exactly one cycle, which is bit period 0 of the next frame.
- R8: When `fsync` is high at a rising edge, that edge is a frame start and the next bit period is period 0, whatever the current count is. A frame cut short this way leaves the receive outputs unchanged and raises no `rx_valid`.
- R9: After the first `fsync`, an edge that ends period 255 is also a frame start even without `fsync`. The transmit snapshot reloads and reception continues.
- R10: After reset and until the first `fsync`, `tx_bit` is 1, `rx_valid` is 0 and all receive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame start marker, sampled on the rising edge |
| if_en | input | N_IF | Per-interface transmit enable |
| tx_b1 | input | 8*N_IF | B1 holding bytes, interface i at [8i+7:8i] |
| tx_b2 | input | 8*N_IF | B2 holding bytes |
| tx_d | input | 2*N_IF | D-channel bit pairs, interface i at [2i+1:2i] |
| tx_bit | output | 1 | Serial transmit line |
| rx_bit | input | 1 | Serial receive line |
| rx_b1 | output | 8*N_IF | Received B1 bytes |
| rx_b2 | output | 8*N_IF | Received B2 bytes |
| rx_d | output | 2*N_IF | Received D-channel bit pairs |
| rx_valid | output | 1 | One-cycle strobe when the receive outputs are updated |

## Verification
The transmit side is checked in every bit period against three kinds of frame: random bytes with random enable masks, all-zero bytes with every interface enabled, and a frame with every interface disabled. The all-zero frame shows whether the masked D positions and the spare slots stay high. The disabled frame shows whether the enable snapshot is applied. Holding inputs change halfway through each frame, which shows whether data is taken at the frame start or continuously. Random receive frames separate the meaningful bit positions from the ignored ones. An early sync pulse, and a frame boundary reached without any pulse, test the resync and free-running paths. An idle stretch before the first sync pulse tests the reset state.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  localparam int SLOTS_PER_IF = 3;

  typedef enum logic [1:0] {
    CH_B1 = 2'd0,
    CH_B2 = 2'd1,
    CH_D  = 2'd2
  } chan_e;

  // slot number carrying channel ch of interface ifn
  function automatic int slot_of(input int ifn, input chan_e ch);
    return ifn * SLOTS_PER_IF + int'(ch);
  endfunction

  // index in the frame image of the first (most significant) bit of a slot;
  // bit period 0 sits at the top of the image
  function automatic int slot_top(input int frame_w, input int slot_w, input int slot);
    return frame_w - 1 - slot * slot_w;
  endfunction

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int FRAME_W = 256,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] pos,
  output logic             locked,
  output logic             frame_start,
  output logic             frame_end
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] pos_q, pos_n;
  logic             locked_q, locked_n;

  always_comb begin
    frame_end   = locked_q && (pos_q == LAST);
    frame_start = fsync || frame_end;
    locked_n    = locked_q || fsync;
    if (frame_start) begin
      pos_n = '0;
    end else if (locked_q) begin
      pos_n = pos_q + 1'b1;
    end else begin
      pos_n = pos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      pos_q    <= pos_n;
      locked_q <= locked_n;
    end
  end

  assign pos    = pos_q;
  assign locked = locked_q;

  // R8
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos == '0) && locked);

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !frame_start) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_pkg::*;
#(
  parameter int N_IF    = 10,
  parameter int SLOT_W  = 8,
  parameter int D_W     = 2,
  parameter int FRAME_W = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [N_IF-1:0]        if_en,
  input  logic [N_IF*SLOT_W-1:0] tx_b1,
  input  logic [N_IF*SLOT_W-1:0] tx_b2,
  input  logic [N_IF*D_W-1:0]    tx_d,
  output logic                   tx_bit
);

  logic [FRAME_W-1:0] img;
  logic [FRAME_W-1:0] sh_q, sh_n;

  // frame image: idle-high everywhere, enabled interfaces overlay their slots
  always_comb begin
    img = '1;
    for (int i = 0; i < N_IF; i++) begin
      if (if_en[i]) begin
        img[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_B1)) -: SLOT_W] = tx_b1[i*SLOT_W +: SLOT_W];
        img[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_B2)) -: SLOT_W] = tx_b2[i*SLOT_W +: SLOT_W];
        img[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_D))  -: D_W]    = tx_d[i*D_W +: D_W];
      end
    end
  end

  always_comb begin
    if (load) begin
      sh_n = img;
    end else begin
      sh_n = {sh_q[FRAME_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_n;
    end
  end

  assign tx_bit = sh_q[FRAME_W-1];

  // R1
  shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sh_q[0] == 1'b1));

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_pkg::*;
#(
  parameter int N_IF    = 10,
  parameter int SLOT_W  = 8,
  parameter int D_W     = 2,
  parameter int FRAME_W = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_bit,
  input  logic                   capture,
  output logic [N_IF*SLOT_W-1:0] rx_b1,
  output logic [N_IF*SLOT_W-1:0] rx_b2,
  output logic [N_IF*D_W-1:0]    rx_d,
  output logic                   rx_valid
);

  logic                   smp_q;
  logic [FRAME_W-2:0]     hist_q;
  logic [FRAME_W-1:0]     full;
  logic [N_IF*SLOT_W-1:0] b1_q, b1_n, b2_q, b2_n;
  logic [N_IF*D_W-1:0]    d_q, d_n;
  logic                   val_q;

  // line sampled mid-bit on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
    end else begin
      smp_q <= rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[FRAME_W-3:0], smp_q};
    end
  end

  always_comb begin
    full = {hist_q, smp_q};
    b1_n = b1_q;
    b2_n = b2_q;
    d_n  = d_q;
    for (int i = 0; i < N_IF; i++) begin
      b1_n[i*SLOT_W +: SLOT_W] = full[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_B1)) -: SLOT_W];
      b2_n[i*SLOT_W +: SLOT_W] = full[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_B2)) -: SLOT_W];
      d_n[i*D_W +: D_W]        = full[slot_top(FRAME_W, SLOT_W, slot_of(i, CH_D))  -: D_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_q <= '0;
      b2_q <= '0;
      d_q  <= '0;
    end else if (capture) begin
      b1_q <= b1_n;
      b2_q <= b2_n;
      d_q  <= d_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
    end else begin
      val_q <= capture;
    end
  end

  assign rx_b1    = b1_q;
  assign rx_b2    = b2_q;
  assign rx_d     = d_q;
  assign rx_valid = val_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_b1) && $stable(rx_b2) && $stable(rx_d)));

endmodule

// File: rtl/tdm_bri_mux.sv
module tdm_bri_mux #(
  parameter int N_IF   = 10,
  parameter int N_SLOT = 32,
  parameter int SLOT_W = 8,
  parameter int D_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fsync,
  input  logic [N_IF-1:0]        if_en,
  input  logic [N_IF*SLOT_W-1:0] tx_b1,
  input  logic [N_IF*SLOT_W-1:0] tx_b2,
  input  logic [N_IF*D_W-1:0]    tx_d,
  output logic                   tx_bit,
  input  logic                   rx_bit,
  output logic [N_IF*SLOT_W-1:0] rx_b1,
  output logic [N_IF*SLOT_W-1:0] rx_b2,
  output logic [N_IF*D_W-1:0]    rx_d,
  output logic                   rx_valid
);

  localparam int FRAME_W  = N_SLOT * SLOT_W;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int USED_BIT = N_IF * tdm_pkg::SLOTS_PER_IF * SLOT_W;

  // asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_i = rsync_q[1];

  logic [CNT_W-1:0] pos;
  logic             locked;
  logic             frame_start;
  logic             frame_end;

  tdm_frame_counter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) i_cnt (
    .clk         (clk),
    .rst_n       (rst_i),
    .fsync       (fsync),
    .pos         (pos),
    .locked      (locked),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  tdm_tx_path #(
    .N_IF    (N_IF),
    .SLOT_W  (SLOT_W),
    .D_W     (D_W),
    .FRAME_W (FRAME_W)
  ) i_tx (
    .clk    (clk),
    .rst_n  (rst_i),
    .load   (frame_start),
    .if_en  (if_en),
    .tx_b1  (tx_b1),
    .tx_b2  (tx_b2),
    .tx_d   (tx_d),
    .tx_bit (tx_bit)
  );

  tdm_rx_path #(
    .N_IF    (N_IF),
    .SLOT_W  (SLOT_W),
    .D_W     (D_W),
    .FRAME_W (FRAME_W)
  ) i_rx (
    .clk      (clk),
    .rst_n    (rst_i),
    .rx_bit   (rx_bit),
    .capture  (frame_end),
    .rx_b1    (rx_b1),
    .rx_b2    (rx_b2),
    .rx_d     (rx_d),
    .rx_valid (rx_valid)
  );

  // position decode used only by the checks below
  logic [CNT_W-1:0] a_slot;
  logic [CNT_W-1:0] a_bit;
  assign a_slot = pos / CNT_W'(SLOT_W);
  assign a_bit  = pos % CNT_W'(SLOT_W);

  // R10
  prelock_idle_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !locked |-> tx_bit);

  // R4
  spare_slot_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (locked && (int'(pos) >= USED_BIT)) |-> tx_bit);

  // R3
  d_mask_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (locked && (int'(pos) < USED_BIT) && ((a_slot % CNT_W'(3)) == CNT_W'(2))
     && (int'(a_bit) >= D_W)) |-> tx_bit);

  // R7
  valid_align_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rx_valid |-> (locked && (pos == '0)));

endmodule

// File: tb/test_tdm_bri_mux.sv
module test_tdm_bri_mux;

  localparam int CLK_PERIOD = 10;
  localparam int NIF = 10;
  localparam int FW  = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fsync = 1'b0;
  logic [NIF-1:0]    if_en = '0;
  logic [NIF*8-1:0]  tx_b1 = '0;
  logic [NIF*8-1:0]  tx_b2 = '0;
  logic [NIF*2-1:0]  tx_d = '0;
  logic              tx_bit;
  logic              rx_bit = 1'b0;
  logic [NIF*8-1:0]  rx_b1;
  logic [NIF*8-1:0]  rx_b2;
  logic [NIF*2-1:0]  rx_d;
  logic              rx_valid;

  int  checks = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  prev_full = 1'b0;

  // snapshot of what the design loaded at the current frame start
  logic [7:0]     cb1 [NIF];
  logic [7:0]     cb2 [NIF];
  logic [1:0]     cd  [NIF];
  logic [NIF-1:0] cen;
  // expected receive outputs
  logic [7:0]     eb1 [NIF];
  logic [7:0]     eb2 [NIF];
  logic [1:0]     ed  [NIF];

  tdm_bri_mux i_tdm_bri_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .if_en    (if_en),
    .tx_b1    (tx_b1),
    .tx_b2    (tx_b2),
    .tx_d     (tx_d),
    .tx_bit   (tx_bit),
    .rx_bit   (rx_bit),
    .rx_b1    (rx_b1),
    .rx_b2    (rx_b2),
    .rx_d     (rx_d),
    .rx_valid (rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx(input int t);
    int slot, k, ifn, ch;
    slot = t / 8;
    k    = t % 8;
    if (slot >= NIF * 3) return 1'b1;
    ifn = slot / 3;
    ch  = slot % 3;
    if (!cen[ifn]) return 1'b1;
    if (ch == 0) return cb1[ifn][7-k];
    if (ch == 1) return cb2[ifn][7-k];
    if (k < 2) return cd[ifn][1-k];
    return 1'b1;
  endfunction

  function automatic string tx_tag(input int t);
    int slot;
    slot = t / 8;
    if (slot >= NIF * 3) return "R4";
    if (!cen[slot/3]) return "R5";
    if ((slot % 3) == 2 && (t % 8) >= 2) return "R3";
    if ((slot % 3) == 2) return "R3 R1";
    return "R1 R2";
  endfunction

  task automatic snap();
    for (int i = 0; i < NIF; i++) begin
      cb1[i] = tx_b1[i*8 +: 8];
      cb2[i] = tx_b2[i*8 +: 8];
      cd[i]  = tx_d[i*2 +: 2];
    end
    cen = if_en;
  endtask

  task automatic set_data(input int mode);
    for (int i = 0; i < NIF; i++) begin
      tx_b1[i*8 +: 8] = (mode == 1) ? 8'h00 : 8'($urandom());
      tx_b2[i*8 +: 8] = (mode == 1) ? 8'h00 : 8'($urandom());
      tx_d[i*2 +: 2]  = (mode == 1) ? 2'b00 : 2'($urandom());
    end
  endtask

  // runs one frame from bit period 0; stop_at < FW cuts it short with fsync
  task automatic run_frame(input int stop_at, input bit fs_end, input logic [NIF-1:0] nen,
                           input int nmode, input string note);
    logic [FW-1:0] rxf;
    logic          e;
    for (int w = 0; w < FW/32; w++) rxf[w*32 +: 32] = $urandom();
    for (int t = 0; t < stop_at; t++) begin
      rx_bit = rxf[t];
      fsync  = (t == stop_at - 1) && ((stop_at < FW) || fs_end);
      if (t == 50) begin
        // R6: inputs change mid-frame, must only matter for the next frame
        if_en = nen;
        set_data(nmode);
      end
      @(negedge clk);
      e = exp_tx(t);
      chk(tx_bit === e, {tx_tag(t), " R6 ", note}, 32'(tx_bit), 32'(e));
      chk(rx_valid === (t == 0 && prev_full), {"R7 ", note}, 32'(rx_valid), 32'(t == 0 && prev_full));
      if (t == stop_at - 1) snap();
      @(posedge clk);
      #1;
    end
    fsync = 1'b0;
    if (stop_at == FW) begin
      for (int i = 0; i < NIF; i++) begin
        for (int k = 0; k < 8; k++) begin
          eb1[i][7-k] = rxf[(3*i)*8 + k];
          eb2[i][7-k] = rxf[(3*i+1)*8 + k];
        end
        ed[i][1] = rxf[(3*i+2)*8];
        ed[i][0] = rxf[(3*i+2)*8 + 1];
      end
      prev_full = 1'b1;
    end else begin
      prev_full = 1'b0;
    end
    for (int i = 0; i < NIF; i++) begin
      chk(rx_b1[i*8 +: 8] === eb1[i], {"R2 R7 ", note}, 32'(rx_b1[i*8 +: 8]), 32'(eb1[i]));
      chk(rx_b2[i*8 +: 8] === eb2[i], {"R2 R7 ", note}, 32'(rx_b2[i*8 +: 8]), 32'(eb2[i]));
      chk(rx_d[i*2 +: 2] === ed[i], {"R3 R4 ", note}, 32'(rx_d[i*2 +: 2]), 32'(ed[i]));
    end
  endtask

  initial begin
    bit idle_ok;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NIF; i++) begin
      eb1[i] = '0;
      eb2[i] = '0;
      ed[i]  = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R10: state after reset
    @(negedge clk);
    chk(tx_bit === 1'b1, "R10 tx idle", 32'(tx_bit), 32'd1);
    chk(rx_valid === 1'b0, "R10 valid low", 32'(rx_valid), 32'd0);
    chk(rx_b1 === '0 && rx_b2 === '0 && rx_d === '0, "R10 rx cleared", 32'(rx_b1[31:0]), 32'd0);

    // R10: no framing before the first sync pulse, whatever arrives on the line
    idle_ok = 1'b1;
    set_data(0);
    if_en = '1;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk);
      #1 rx_bit = 1'($urandom());
      @(negedge clk);
      if (tx_bit !== 1'b1 || rx_valid !== 1'b0) idle_ok = 1'b0;
    end
    chk(idle_ok, "R10 idle before sync", 32'(idle_ok), 32'd1);

    // first frame start
    @(posedge clk);
    #1;
    set_data(0);
    if_en = '1;
    snap();
    fsync = 1'b1;
    @(posedge clk);
    #1 fsync = 1'b0;

    run_frame(FW, 1'b1, '1,           1, "random all enabled");
    run_frame(FW, 1'b1, '0,           0, "zero data, masks high");
    run_frame(FW, 1'b1, NIF'($urandom()), 0, "all disabled");
    run_frame(FW, 1'b0, NIF'($urandom()), 0, "random mask, no sync at end");
    run_frame(FW, 1'b1, NIF'($urandom()), 0, "R9 free-running frame");
    run_frame(100, 1'b1, NIF'($urandom()), 0, "R8 cut short");
    run_frame(FW, 1'b1, '1,           0, "R8 after resync");
    for (int f = 0; f < 4; f++) begin
      run_frame(FW, 1'b1, NIF'($urandom()), 0, "random");
    end

    // R7: strobe in the first period of the next frame, then low
    @(negedge clk);
    chk(rx_valid === 1'b1, "R7 strobe high", 32'(rx_valid), 32'd1);
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(rx_valid === 1'b0, "R7 strobe one cycle", 32'(rx_valid), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule